// File: doc/BRIEF.md
# Host Command Packet Parser

This block sits behind an SPI slave byte shifter and turns the stream of bytes from the host into framed command packets. Each packet opens with an escape byte, carries an opcode and a payload whose length the opcode fixes, and closes with a folded XOR checksum. When the checksum matches, the opcode is decoded into single-cycle control strobes: flush the buffers, enable key transmission, heartbeat and identity reply requests, and a host resend notice. It also drives a serial write port into the wake-up key mask and the mode and level of one general-purpose pin.

Responses the parser owes the host are placed on a transmit byte port with a valid/ready handshake. These are the resend request for a bad or unknown packet, and the pin mode and pin level reports. The parser also watches the spacing between received bytes. A byte that arrives too soon after the previous one spoils the packet. A silence longer than the allowed maximum quietly drops whatever was partly received.

Gaps are counted in clock cycles through the `MinGap` and `MaxGap` parameters, which should be set to the interval limits at the system clock rate.

Top module: `host_cmd_parser`

## Requirements
- R1: While no packet is open, any received byte other than 1Bh is ignored: no strobe, no mask write, no response byte.
- R2: The closing byte must equal the XOR of all earlier bytes of the packet, further XORed with C0h when bit 7 of that XOR is set. A mismatch executes nothing and queues the three bytes 80h, A5h, 25h.
- R3: A good A0h packet pulses `clearBufs` for one cycle and returns the pin to input mode (mode 0) with the level low.
- R4: Good A1h, A2h, F2h and A5h packets each pulse only their own strobe (`keyTxEnable`, `heartbeatReq`, `idReq`, `hostResendReq`) for one cycle, beginning the cycle after the checksum byte is taken.
- R5: A7h with I/O number 0 and mode byte 0..3 sets `gpioMode` to that value (0 input, 1 output, 2 switch, 3 LED). `gpioOe` is high only in output mode. `gpioOut` is low on entry to output mode and whenever the pin is not in output mode.
- R6: A7h with I/O number 0 and mode byte 4 queues 80h, A7h, 00h, mode, checksum, where the checksum uses the R2 rule. Each byte is held on `txByte` until `txReady` accepts it.
- R7: A8h with I/O number 0 and data 0 or 1 sets `gpioOut` to that value only in output mode. In any other mode the write is ignored.
- R8: A8h with I/O number 0 and data 2 queues 80h, A8h, 00h, level, checksum. The level is `gpioOut` in output mode and `gpioIn` otherwise.
- R9: A9h carries `MaskBytes` payload bytes. Only after a good checksum are they written on consecutive cycles with `wakeWrIdx` running from 0 upward and `wakeWrData` holding the byte in arrival order.
- R10: An opcode outside the known set (A0h, A1h, A2h, A5h, A7h, A8h, A9h, F2h) queues the R2 resend response. All further bytes are discarded until the line has been silent longer than `MaxGap` cycles.
- R11: If more than `MaxGap` cycles pass between two bytes of an open packet, the partial packet is dropped without a response. The next 1Bh starts a fresh packet.
- R12: A byte inside an open packet that arrives fewer than `MinGap` cycles after the previous byte queues the resend response, and the packet is not executed.
- R13: A7h or A8h with a non-zero I/O number, a mode byte above 4, or a data byte above 2 changes nothing and queues no response.
- R14: After reset the pin is in input mode with `gpioOut` and `gpioOe` low, and `txValid` and every strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | A received host byte is present this cycle |
| rxByte | input | 8 | Received host byte |
| txReady | input | 1 | Transmit side accepts `txByte` this cycle |
| gpioIn | input | 1 | Sampled level of the general-purpose pin |
| txValid | output | 1 | A response byte is offered |
| txByte | output | 8 | Response byte |
| clearBufs | output | 1 | One-cycle pulse: flush buffers, back to power-on state |
| keyTxEnable | output | 1 | One-cycle pulse: key transmission enabled |
| heartbeatReq | output | 1 | One-cycle pulse: heartbeat reply wanted |
| idReq | output | 1 | One-cycle pulse: identity reply wanted |
| hostResendReq | output | 1 | One-cycle pulse: host asked for a resend |
| wakeWrEn | output | 1 | Wake-up mask write strobe |
| wakeWrIdx | output | $clog2(MaskBytes) | Wake-up mask byte index |
| wakeWrData | output | 8 | Wake-up mask byte |
| gpioMode | output | 2 | Pin mode: 0 input, 1 output, 2 switch, 3 LED |
| gpioOut | output | 1 | Pin drive level |
| gpioOe | output | 1 | Pin output enable |

## Verification
On every cycle the assertions check several things. The strobes never overlap. A packet is never both executed and rejected in the same cycle. The pin level stays low outside output mode and starts low on entry to output mode. Offered response bytes hold steady while the transmit side stalls. Mask writes step their index by one. A timed-out open packet returns to idle. The scenarios alone show the packet-level behaviour: which byte sequences run a command and which are ignored or answered with a resend. They also show the exact contents and order of the report packets, the mode-dependent level reported, and the recovery after an early byte, a silent gap or an unknown opcode.

// File: rtl/hcp_pkg.sv
package hcp_pkg;

  localparam logic [7:0] ESC_BYTE  = 8'h1B;
  localparam logic [7:0] RSP_HDR   = 8'h80;
  localparam logic [7:0] OP_INIT   = 8'hA0;
  localparam logic [7:0] OP_READY  = 8'hA1;
  localparam logic [7:0] OP_BEAT   = 8'hA2;
  localparam logic [7:0] OP_RESEND = 8'hA5;
  localparam logic [7:0] OP_MODE   = 8'hA7;
  localparam logic [7:0] OP_DATA   = 8'hA8;
  localparam logic [7:0] OP_WAKE   = 8'hA9;
  localparam logic [7:0] OP_IDENT  = 8'hF2;

  typedef enum logic [1:0] {
    GPIO_IN  = 2'd0,
    GPIO_OUT = 2'd1,
    GPIO_SW  = 2'd2,
    GPIO_LED = 2'd3
  } gpio_mode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       payWr;
    logic [7:0] payIdx;
    logic [7:0] payByte;
    logic       exec;
    logic       resend;
    logic [7:0] opcode;
  } hcp_strobe_t;

  function automatic logic [7:0] foldCks(input logic [7:0] x);
    return x[7] ? (x ^ 8'hC0) : x;
  endfunction

  function automatic logic opKnown(input logic [7:0] op);
    return (op == OP_INIT) || (op == OP_READY) || (op == OP_BEAT) ||
           (op == OP_RESEND) || (op == OP_MODE) || (op == OP_DATA) ||
           (op == OP_WAKE) || (op == OP_IDENT);
  endfunction

  function automatic int payLen(input logic [7:0] op, input int maskBytes);
    if (op == OP_WAKE) return maskBytes;
    if (op == OP_MODE || op == OP_DATA) return 2;
    return 0;
  endfunction

endpackage

// File: rtl/hcp_ctrl.sv
module hcp_ctrl
  import hcp_pkg::*;
#(
  parameter int MinGap    = 8,
  parameter int MaxGap    = 100,
  parameter int MaskBytes = 15
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  output hcp_strobe_t stb
);

  localparam int CntW = $clog2(MaxGap + 2);
  localparam logic [CntW-1:0] StaleVal = CntW'(MaxGap + 1);
  localparam logic [CntW-1:0] MinVal   = CntW'(MinGap);

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_PAY, S_CKS, S_DROP} pstate_e;

  pstate_e        state, effState, nextState;
  logic [CntW-1:0] gapCnt;
  logic [7:0]     acc, opcode, payIdx, payLast;
  logic           stale, early;

  assign stale    = (gapCnt == StaleVal);
  assign early    = (gapCnt < MinVal);
  assign effState = (state != S_IDLE && stale) ? S_IDLE : state;

  always_comb begin
    nextState   = effState;
    stb         = '0;
    stb.opcode  = opcode;
    stb.payIdx  = payIdx;
    stb.payByte = rxByte;
    if (rxValid) begin
      unique case (effState)
        S_IDLE: if (rxByte == ESC_BYTE) nextState = S_OPC;
        S_OPC: begin
          if (early || !opKnown(rxByte)) begin
            stb.resend = 1'b1;
            nextState  = S_DROP;
          end else if (payLen(rxByte, MaskBytes) == 0) begin
            nextState = S_CKS;
          end else begin
            nextState = S_PAY;
          end
        end
        S_PAY: begin
          if (early) begin
            stb.resend = 1'b1;
            nextState  = S_DROP;
          end else begin
            stb.payWr = 1'b1;
            if (payIdx == payLast) nextState = S_CKS;
          end
        end
        S_CKS: begin
          if (!early && rxByte == foldCks(acc)) stb.exec = 1'b1;
          else stb.resend = 1'b1;
          nextState = S_IDLE;
        end
        default: nextState = S_DROP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      gapCnt  <= StaleVal;
      acc     <= '0;
      opcode  <= '0;
      payIdx  <= '0;
      payLast <= '0;
    end else begin
      state <= nextState;
      if (rxValid) gapCnt <= CntW'(1);
      else if (!stale) gapCnt <= gapCnt + CntW'(1);
      if (rxValid) begin
        if (effState == S_IDLE) acc <= rxByte;
        else if (effState == S_OPC || effState == S_PAY) acc <= acc ^ rxByte;
        if (effState == S_OPC) begin
          opcode  <= rxByte;
          payIdx  <= '0;
          payLast <= 8'(payLen(rxByte, MaskBytes) - 1);
        end
        if (stb.payWr) payIdx <= payIdx + 8'd1;
      end
    end
  end

  // R11: an open packet left silent past the limit falls back to idle
  assert_timeout_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && stale && !rxValid) |=> (state == S_IDLE));

  // R2: a packet is never both run and rejected
  assert_exec_excl_resend_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.exec && stb.resend));

endmodule

// File: rtl/hcp_dpath.sv
module hcp_dpath
  import hcp_pkg::*;
#(
  parameter int MaskBytes = 15,
  localparam int IdxW     = $clog2(MaskBytes)
) (
  input  logic            clk,
  input  logic            rstN,
  input  hcp_strobe_t     stb,
  input  logic            gpioIn,
  input  logic            txReady,
  output logic            txValid,
  output logic [7:0]      txByte,
  output logic            clearBufs,
  output logic            keyTxEnable,
  output logic            heartbeatReq,
  output logic            idReq,
  output logic            hostResendReq,
  output logic            wakeWrEn,
  output logic [IdxW-1:0] wakeWrIdx,
  output logic [7:0]      wakeWrData,
  output logic [1:0]      gpioMode,
  output logic            gpioOut,
  output logic            gpioOe
);

  localparam logic [IdxW-1:0] WakeLast = IdxW'(MaskBytes - 1);

  logic [7:0]      payBuf [MaskBytes];
  gpio_mode_e      mode;
  logic            level, pinLevel;
  logic            wkActive;
  logic [IdxW-1:0] wkCnt;
  logic [7:0]      rspBuf [5];
  logic [2:0]      rspIdx, rspLast;
  logic            rspBusy;
  logic            reqGo, reqShort;
  logic [7:0]      reqOp, reqVal;
  logic            ioZero;

  assign pinLevel = (mode == GPIO_OUT) ? level : gpioIn;
  assign ioZero   = (payBuf[0] == 8'h00);

  // payload capture
  always_ff @(posedge clk) begin
    for (int i = 0; i < MaskBytes; i++)
      if (stb.payWr && stb.payIdx == 8'(i)) payBuf[i] <= stb.payByte;
  end

  // response request decode
  always_comb begin
    reqGo = 1'b0; reqShort = 1'b0; reqOp = '0; reqVal = '0;
    if (stb.resend) begin
      reqGo = 1'b1; reqShort = 1'b1;
    end else if (stb.exec && ioZero) begin
      if (stb.opcode == OP_MODE && payBuf[1] == 8'd4) begin
        reqGo = 1'b1; reqOp = OP_MODE; reqVal = {6'd0, mode};
      end else if (stb.opcode == OP_DATA && payBuf[1] == 8'd2) begin
        reqGo = 1'b1; reqOp = OP_DATA; reqVal = {7'd0, pinLevel};
      end
    end
  end

  // command execution
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clearBufs <= 1'b0; keyTxEnable <= 1'b0; heartbeatReq <= 1'b0;
      idReq <= 1'b0; hostResendReq <= 1'b0;
      mode <= GPIO_IN; level <= 1'b0;
      wkActive <= 1'b0; wkCnt <= '0;
    end else begin
      clearBufs <= 1'b0; keyTxEnable <= 1'b0; heartbeatReq <= 1'b0;
      idReq <= 1'b0; hostResendReq <= 1'b0;
      if (wkActive) begin
        if (wkCnt == WakeLast) wkActive <= 1'b0;
        wkCnt <= wkCnt + IdxW'(1);
      end
      if (stb.exec) begin
        unique case (stb.opcode)
          OP_INIT: begin
            clearBufs <= 1'b1; mode <= GPIO_IN; level <= 1'b0;
          end
          OP_READY:  keyTxEnable   <= 1'b1;
          OP_BEAT:   heartbeatReq  <= 1'b1;
          OP_IDENT:  idReq         <= 1'b1;
          OP_RESEND: hostResendReq <= 1'b1;
          OP_MODE: if (ioZero && payBuf[1] < 8'd4) begin
            mode <= gpio_mode_e'(payBuf[1][1:0]);
            if (payBuf[1][1:0] != GPIO_OUT || mode != GPIO_OUT) level <= 1'b0;
          end
          OP_DATA: if (ioZero && payBuf[1] < 8'd2 && mode == GPIO_OUT)
            level <= payBuf[1][0];
          OP_WAKE: begin
            wkActive <= 1'b1; wkCnt <= '0;
          end
          default: ;
        endcase
      end
    end
  end

  // response sequencer: a request arriving while busy is dropped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspBusy <= 1'b0; rspIdx <= '0; rspLast <= '0;
      for (int i = 0; i < 5; i++) rspBuf[i] <= '0;
    end else if (!rspBusy && reqGo) begin
      rspBusy   <= 1'b1;
      rspIdx    <= '0;
      rspBuf[0] <= RSP_HDR;
      if (reqShort) begin
        rspBuf[1] <= OP_RESEND;
        rspBuf[2] <= foldCks(RSP_HDR ^ OP_RESEND);
        rspLast   <= 3'd2;
      end else begin
        rspBuf[1] <= reqOp;
        rspBuf[2] <= 8'h00;
        rspBuf[3] <= reqVal;
        rspBuf[4] <= foldCks(RSP_HDR ^ reqOp ^ reqVal);
        rspLast   <= 3'd4;
      end
    end else if (rspBusy && txReady) begin
      if (rspIdx == rspLast) rspBusy <= 1'b0;
      else rspIdx <= rspIdx + 3'd1;
    end
  end

  assign txValid    = rspBusy;
  assign txByte     = rspBuf[rspIdx];
  assign wakeWrEn   = wkActive;
  assign wakeWrIdx  = wkCnt;
  assign wakeWrData = payBuf[wkCnt];
  assign gpioMode   = mode;
  assign gpioOut    = level;
  assign gpioOe     = (mode == GPIO_OUT);

  assert_pulses_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({clearBufs, keyTxEnable, heartbeatReq, idReq, hostResendReq}));

  assert_level_low_off_output_R5: assert property (@(posedge clk) disable iff (!rstN)
    (mode != GPIO_OUT) |-> !level);

  assert_output_entry_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(mode) != GPIO_OUT && mode == GPIO_OUT) |-> !level);

  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txByte)));

  assert_wake_idx_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wakeWrEn && $past(wakeWrEn)) |-> (wakeWrIdx == $past(wakeWrIdx) + IdxW'(1)));

endmodule

// File: rtl/host_cmd_parser.sv
module host_cmd_parser
  import hcp_pkg::*;
#(
  parameter int MinGap    = 8,
  parameter int MaxGap    = 100,
  parameter int MaskBytes = 15,
  localparam int IdxW     = $clog2(MaskBytes)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rxValid,
  input  logic [7:0]      rxByte,
  input  logic            txReady,
  input  logic            gpioIn,
  output logic            txValid,
  output logic [7:0]      txByte,
  output logic            clearBufs,
  output logic            keyTxEnable,
  output logic            heartbeatReq,
  output logic            idReq,
  output logic            hostResendReq,
  output logic            wakeWrEn,
  output logic [IdxW-1:0] wakeWrIdx,
  output logic [7:0]      wakeWrData,
  output logic [1:0]      gpioMode,
  output logic            gpioOut,
  output logic            gpioOe
);

  hcp_strobe_t stb;

  hcp_ctrl #(.MinGap(MinGap), .MaxGap(MaxGap), .MaskBytes(MaskBytes)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte), .stb(stb)
  );

  hcp_dpath #(.MaskBytes(MaskBytes)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .gpioIn(gpioIn), .txReady(txReady),
    .txValid(txValid), .txByte(txByte), .clearBufs(clearBufs),
    .keyTxEnable(keyTxEnable), .heartbeatReq(heartbeatReq), .idReq(idReq),
    .hostResendReq(hostResendReq), .wakeWrEn(wakeWrEn), .wakeWrIdx(wakeWrIdx),
    .wakeWrData(wakeWrData), .gpioMode(gpioMode), .gpioOut(gpioOut), .gpioOe(gpioOe)
  );

endmodule

// File: tb/sim_host_cmd_parser.sv
`timescale 1ns/1ps
module sim_host_cmd_parser;

  localparam int MinGap = 8;
  localparam int MaxGap = 100;
  localparam int MaskBytes = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic txReady = 1'b1;
  logic gpioIn = 1'b0;
  logic txValid, clearBufs, keyTxEnable, heartbeatReq, idReq, hostResendReq;
  logic wakeWrEn, gpioOut, gpioOe;
  logic [3:0] wakeWrIdx;
  logic [7:0] txByte, wakeWrData;
  logic [1:0] gpioMode;

  always #5 clk = ~clk;

  host_cmd_parser #(.MinGap(MinGap), .MaxGap(MaxGap), .MaskBytes(MaskBytes)) u0 (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxByte(rxByte), .txReady(txReady),
    .gpioIn(gpioIn), .txValid(txValid), .txByte(txByte), .clearBufs(clearBufs),
    .keyTxEnable(keyTxEnable), .heartbeatReq(heartbeatReq), .idReq(idReq),
    .hostResendReq(hostResendReq), .wakeWrEn(wakeWrEn), .wakeWrIdx(wakeWrIdx),
    .wakeWrData(wakeWrData), .gpioMode(gpioMode), .gpioOut(gpioOut), .gpioOe(gpioOe)
  );

  int checks = 0;
  int failures = 0;
  int nClr = 0, nTxEn = 0, nBeat = 0, nId = 0, nRsd = 0;
  int txN = 0, wkN = 0;
  logic [7:0] txLog [0:255];
  logic [7:0] wkData [0:63];
  logic [3:0] wkIdx [0:63];
  logic [7:0] pkt [0:19];
  logic [7:0] expTx [0:4];
  bit done = 0;

  always @(negedge clk) begin
    if (clearBufs) nClr++;
    if (keyTxEnable) nTxEn++;
    if (heartbeatReq) nBeat++;
    if (idReq) nId++;
    if (hostResendReq) nRsd++;
    if (txValid && txReady && txN < 256) begin txLog[txN] = txByte; txN++; end
    if (wakeWrEn && wkN < 64) begin wkData[wkN] = wakeWrData; wkIdx[wkN] = wakeWrIdx; wkN++; end
  end

  function automatic logic [7:0] fold(input logic [7:0] x);
    return x[7] ? (x ^ 8'hC0) : x;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic putByte(input logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxByte = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  // sends pkt[0..n-1] and a checksum; gap between bytes = 10 cycles
  task automatic sendPkt(input int n, input logic corrupt);
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 0; i < n; i++) begin
      putByte(pkt[i]); acc = acc ^ pkt[i]; waitCyc(8);
    end
    putByte(fold(acc) ^ {7'd0, corrupt});
  endtask

  task automatic chkTx(input string req, input int base, input int n);
    chk(req, txN - base, n);
    for (int i = 0; i < n; i++) chk(req, txLog[base + i], expTx[i]);
  endtask

  task automatic t_reset();
    chk("R14", gpioMode, 0); chk("R14", gpioOut, 0); chk("R14", gpioOe, 0);
    chk("R14", txValid, 0);
    chk("R14", {clearBufs, keyTxEnable, heartbeatReq, idReq, hostResendReq, wakeWrEn}, 0);
  endtask

  task automatic t_idle_garbage();
    int tb = txN; int e = nTxEn;
    putByte(8'hA1); waitCyc(10); putByte(8'h7A); waitCyc(10); putByte(8'h55); waitCyc(10);
    chk("R1", txN - tb, 0); chk("R1", nTxEn - e, 0); chk("R1", wkN, 0);
  endtask

  task automatic t_simple();
    int c0 = nClr, e0 = nTxEn, b0 = nBeat, i0 = nId, r0 = nRsd;
    pkt[0] = 8'h1B; pkt[1] = 8'hA2; sendPkt(2, 0);
    chk("R4", heartbeatReq, 1);
    waitCyc(2); chk("R4", heartbeatReq, 0);
    pkt[1] = 8'hA1; sendPkt(2, 0); waitCyc(10);
    pkt[1] = 8'hF2; sendPkt(2, 0); waitCyc(10);
    pkt[1] = 8'hA5; sendPkt(2, 0); waitCyc(10);
    chk("R4", nBeat - b0, 1); chk("R4", nTxEn - e0, 1); chk("R4", nId - i0, 1);
    chk("R4", nRsd - r0, 1); chk("R4", nClr - c0, 0);
  endtask

  task automatic t_bad_cks();
    int tb = txN; int e = nTxEn;
    pkt[0] = 8'h1B; pkt[1] = 8'hA1; sendPkt(2, 1); waitCyc(20);
    chk("R2", nTxEn - e, 0);
    expTx[0] = 8'h80; expTx[1] = 8'hA5; expTx[2] = 8'h25; chkTx("R2", tb, 3);
    waitCyc(10);
  endtask

  task automatic t_mode();
    int tb;
    pkt[0] = 8'h1B; pkt[1] = 8'hA7; pkt[2] = 8'h00; pkt[3] = 8'h01; sendPkt(4, 0); waitCyc(2);
    chk("R5", gpioMode, 1); chk("R5", gpioOe, 1); chk("R5", gpioOut, 0);
    pkt[3] = 8'h03; sendPkt(4, 0); waitCyc(2);
    chk("R5", gpioMode, 3); chk("R5", gpioOe, 0);
    pkt[3] = 8'h05; sendPkt(4, 0); waitCyc(10);
    chk("R13", gpioMode, 3);
    pkt[2] = 8'h01; pkt[3] = 8'h01; sendPkt(4, 0); waitCyc(2);
    chk("R13", gpioMode, 3);
    // status request with a stalled transmit side
    tb = txN; txReady = 1'b0;
    pkt[2] = 8'h00; pkt[3] = 8'h04; sendPkt(4, 0); waitCyc(6);
    chk("R6", txValid, 1); chk("R6", txByte, 8'h80);
    txReady = 1'b1; waitCyc(12);
    expTx[0] = 8'h80; expTx[1] = 8'hA7; expTx[2] = 8'h00; expTx[3] = 8'h03;
    expTx[4] = fold(8'h80 ^ 8'hA7 ^ 8'h03); chkTx("R6", tb, 5);
  endtask

  task automatic t_data();
    int tb;
    // not output (LED mode): write ignored
    pkt[0] = 8'h1B; pkt[1] = 8'hA8; pkt[2] = 8'h00; pkt[3] = 8'h01; sendPkt(4, 0); waitCyc(2);
    chk("R7", gpioOut, 0);
    gpioIn = 1'b1; tb = txN;
    pkt[3] = 8'h02; sendPkt(4, 0); waitCyc(12);
    expTx[0] = 8'h80; expTx[1] = 8'hA8; expTx[2] = 8'h00; expTx[3] = 8'h01;
    expTx[4] = fold(8'h80 ^ 8'hA8 ^ 8'h01); chkTx("R8", tb, 5);
    pkt[1] = 8'hA7; pkt[3] = 8'h01; sendPkt(4, 0); waitCyc(10);
    pkt[1] = 8'hA8; pkt[3] = 8'h01; sendPkt(4, 0); waitCyc(2);
    chk("R7", gpioOut, 1);
    pkt[2] = 8'h01; pkt[3] = 8'h00; sendPkt(4, 0); waitCyc(2);
    chk("R13", gpioOut, 1);
    pkt[2] = 8'h00; pkt[3] = 8'h07; tb = txN; sendPkt(4, 0); waitCyc(12);
    chk("R13", gpioOut, 1); chk("R13", txN - tb, 0);
    gpioIn = 1'b0; tb = txN;
    pkt[3] = 8'h02; sendPkt(4, 0); waitCyc(12);
    expTx[3] = 8'h01; expTx[4] = fold(8'h80 ^ 8'hA8 ^ 8'h01); chkTx("R8", tb, 5);
    pkt[1] = 8'hA7; pkt[3] = 8'h02; sendPkt(4, 0); waitCyc(2);
    chk("R5", gpioOut, 0); chk("R5", gpioOe, 0); chk("R5", gpioMode, 2);
    pkt[1] = 8'hA7; pkt[3] = 8'h01; sendPkt(4, 0); waitCyc(10);
    pkt[1] = 8'hA8; pkt[3] = 8'h01; sendPkt(4, 0); waitCyc(10);
  endtask

  task automatic t_init();
    int c = nClr;
    chk("R3", gpioOut, 1);
    pkt[0] = 8'h1B; pkt[1] = 8'hA0; sendPkt(2, 0);
    chk("R3", clearBufs, 1);
    waitCyc(2);
    chk("R3", clearBufs, 0); chk("R3", nClr - c, 1);
    chk("R3", gpioMode, 0); chk("R3", gpioOut, 0); chk("R3", gpioOe, 0);
    waitCyc(10);
  endtask

  task automatic t_wake();
    int w0, tb;
    pkt[0] = 8'h1B; pkt[1] = 8'hA9;
    for (int i = 0; i < MaskBytes; i++) pkt[2 + i] = 8'h30 + 8'(i * 3);
    w0 = wkN; tb = txN;
    sendPkt(2 + MaskBytes, 1); waitCyc(25);
    chk("R9", wkN - w0, 0);
    expTx[0] = 8'h80; expTx[1] = 8'hA5; expTx[2] = 8'h25; chkTx("R2", tb, 3);
    sendPkt(2 + MaskBytes, 0); waitCyc(25);
    chk("R9", wkN - w0, MaskBytes);
    for (int i = 0; i < MaskBytes; i++) begin
      chk("R9", wkIdx[w0 + i], i);
      chk("R9", wkData[w0 + i], 8'h30 + 8'(i * 3));
    end
  endtask

  task automatic t_unknown();
    int tb = txN; int e = nTxEn;
    putByte(8'h1B); waitCyc(8); putByte(8'h33); waitCyc(8);
    putByte(8'h1B); waitCyc(8); putByte(8'hA1); waitCyc(8); putByte(8'h7A);
    waitCyc(20);
    chk("R10", nTxEn - e, 0);
    expTx[0] = 8'h80; expTx[1] = 8'hA5; expTx[2] = 8'h25; chkTx("R10", tb, 3);
    waitCyc(MaxGap + 10);
    pkt[0] = 8'h1B; pkt[1] = 8'hA1; sendPkt(2, 0); waitCyc(2);
    chk("R10", nTxEn - e, 1);
  endtask

  task automatic t_timeout();
    int tb = txN; int e = nTxEn;
    putByte(8'h1B); waitCyc(8); putByte(8'hA1);
    waitCyc(MaxGap + 20); putByte(8'h7A); waitCyc(20);
    chk("R11", nTxEn - e, 0); chk("R11", txN - tb, 0);
    pkt[0] = 8'h1B; pkt[1] = 8'hA1; sendPkt(2, 0); waitCyc(2);
    chk("R11", nTxEn - e, 1);
    waitCyc(10);
  endtask

  task automatic t_early();
    int tb = txN; int e = nTxEn;
    putByte(8'h1B); waitCyc(1); putByte(8'hA1); waitCyc(8); putByte(8'h7A);
    waitCyc(20);
    chk("R12", nTxEn - e, 0);
    expTx[0] = 8'h80; expTx[1] = 8'hA5; expTx[2] = 8'h25; chkTx("R12", tb, 3);
    waitCyc(MaxGap + 10);
  endtask

  initial begin
    waitCyc(4); rstN = 1'b1; waitCyc(2);
    t_reset();
    t_idle_garbage();
    t_simple();
    t_bad_cks();
    t_mode();
    t_data();
    t_init();
    t_wake();
    t_unknown();
    t_timeout();
    t_early();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule